// File: doc/BRIEF.md
# Bus Error Status Capture

This block keeps a record of bus errors for a small group of bus masters. Each master reports an error event with a one-cycle valid pulse. The event carries the error kind (a timeout or an error response from a slave), a flag that says whether the failing access was a read or a write, and the failing address. Every master has its own status field in one 32-bit status word. All masters share one error address register. The first error a master reports is frozen in its field. The first error seen while nobody owns the address register is frozen there too. Nothing is overwritten until software has read the record and released it.

Software reaches both registers through a simple register port. A select line picks either the status word or the address register, and the read data is combinational. Writes to the status word are write-one-to-clear on the two lock bits of each master. Error events have no ready signal, so there is no back-pressure. An event is accepted in the cycle its valid is high. The lock state at the start of that cycle decides which parts of the event are kept; the rest is discarded.

Top module: `bus_err_capture`

## Requirements
- R1: After reset, every status field reads 0 and the address register reads 0.
- R2: An error from master m whose field lock is clear is stored one cycle later. The code becomes 01 for a timeout or 10 for a slave error, the R/W bit becomes 1 for a write or 0 for a read, and the field lock is set.
- R3: While master m's field lock is set, its errors leave its code, R/W bit and field lock unchanged.
- R4: The address register loads only when no master holds an address lock. A load sets the address lock of the master whose address was taken. At most one address lock is ever set, and the address stays unchanged while any address lock is set.
- R5: When several masters report errors in the same cycle with no address lock held, the lowest-numbered master supplies the address and takes the address lock. Every reporting master whose field lock is clear still stores its own code and R/W bit.
- R6: Writing the status word with a 1 in master m's field-lock bit clears that lock, the code and the R/W bit. A 0 in that bit leaves them unchanged.
- R7: Writing the status word with a 1 in master m's address-lock bit clears that lock. The address register keeps its value until the next load.
- R8: Master m's field occupies status bits 5m to 5m+4: bits 5m+1:5m hold the code, bit 5m+2 holds R/W, bit 5m+3 holds the field lock, and bit 5m+4 holds the address lock. Bits above the last field read 0, and the code 11 never appears.
- R9: Writes to the address register, and writes to code, R/W or reserved status bits, have no effect.
- R10: An error that arrives in the same cycle as a write clearing a lock that was set is not captured by that lock's field or by the address register. The clear still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | N_MASTERS | Per-master error event strobe |
| err_slave | input | N_MASTERS | Error kind: 1 for slave error, 0 for timeout |
| err_write | input | N_MASTERS | Failing access was a write (1) or a read (0) |
| err_addr | input | N_MASTERS*AW | Failing address of each master, master m at bits m*AW upward |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 for the status word, 1 for the address register |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the selected register |

## Verification
The bench goes after the cases where an error arrives in the same cycle as a clear of a set lock. A design that applied the clear first would capture the new error and overwrite a record software never read. It also drives ties of several masters in one cycle. A wrong priority chain would hand the address to a higher index or set two address locks at once. A design that let a lock also block the other masters' fields would drop their codes. Writes with ones only in the code, R/W and reserved bits, and writes to the address register, check that no stray bit disturbs the frozen record. Clearing an address lock then checks that the old address stays visible until the next load.

// File: rtl/bes_pkg.sv
package bes_pkg;

  // Width of one master's slice of the status word.
  localparam int FIELD_W   = 5;
  // Bit offsets inside a slice.
  localparam int CODE_LSB  = 0;
  localparam int RW_BIT    = 2;
  localparam int FLOCK_BIT = 3;
  localparam int ALOCK_BIT = 4;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'b00,
    ERR_TIMEOUT = 2'b01,
    ERR_SLAVE   = 2'b10,
    ERR_RSVD    = 2'b11
  } err_code_e;

  // Packed MSB first, so the struct maps bit for bit onto a slice.
  typedef struct packed {
    logic      alock;
    logic      flock;
    logic      rw;
    err_code_e code;
  } mst_field_t;

  function automatic err_code_e code_of(input logic slave_err);
    return slave_err ? ERR_SLAVE : ERR_TIMEOUT;
  endfunction

endpackage

// File: rtl/bes_field.sv
// One master's status slice: error code, R/W, field lock, address lock.
module bes_field
  import bes_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_valid,
  input  logic       err_slave,
  input  logic       err_write,
  input  logic       clr_flock,
  input  logic       clr_alock,
  input  logic       set_alock,
  output mst_field_t fld
);

  // The lock as held at the start of the cycle decides capture, so an
  // error racing a clear is dropped (R10).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld <= '0;
    end else begin
      if (err_valid && !fld.flock) begin
        fld.code  <= code_of(err_slave);
        fld.rw    <= err_write;
        fld.flock <= 1'b1;
      end else if (clr_flock) begin
        fld.code  <= ERR_NONE;
        fld.rw    <= 1'b0;
        fld.flock <= 1'b0;
      end

      // set_alock only rises when no lock is held, so it never meets a clear
      if (set_alock) begin
        fld.alock <= 1'b1;
      end else if (clr_alock) begin
        fld.alock <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bes_addr_cap.sv
// Shared error address register with a fixed lowest-index priority.
module bes_addr_cap #(
  parameter int N_MASTERS = 4,
  parameter int AW        = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MASTERS-1:0]    err_valid,
  input  logic [N_MASTERS*AW-1:0] err_addr,
  input  logic                    alock_any,
  output logic [N_MASTERS-1:0]    set_alock,
  output logic [AW-1:0]           addr_q
);

  logic [N_MASTERS:0]   taken;
  logic [N_MASTERS-1:0] grant;
  logic [AW-1:0]        addr_mux;
  logic                 load;

  assign taken[0] = 1'b0;

  // Priority chain: a master wins only if no lower index is reporting.
  for (genvar i = 0; i < N_MASTERS; i++) begin : g_prio
    assign grant[i]   = err_valid[i] & ~taken[i];
    assign taken[i+1] = taken[i] | err_valid[i];
  end

  // grant is one-hot or zero, so an AND-OR mux is enough.
  always_comb begin
    addr_mux = '0;
    for (int i = 0; i < N_MASTERS; i++) begin
      addr_mux = addr_mux | (err_addr[i*AW +: AW] & {AW{grant[i]}});
    end
  end

  assign load      = ~alock_any & taken[N_MASTERS];
  assign set_alock = load ? grant : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= addr_mux;
    end
  end

endmodule

// File: rtl/bes_regif.sv
// Register port: write-one-to-clear decode and read mux.
module bes_regif
  import bes_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int AW        = 32,
  parameter int DW        = 32
) (
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [DW-1:0]        reg_wdata,
  input  logic [DW-1:0]        status_word,
  input  logic [AW-1:0]        addr_q,
  output logic [N_MASTERS-1:0] clr_flock,
  output logic [N_MASTERS-1:0] clr_alock,
  output logic [DW-1:0]        reg_rdata
);

  logic          wr_status;
  logic [DW-1:0] addr_ext;

  // Address register is read-only; only status writes decode (R9).
  assign wr_status = reg_wr & ~reg_sel;

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_clr
    localparam int BASE = m * FIELD_W;
    assign clr_flock[m] = wr_status & reg_wdata[BASE + FLOCK_BIT];
    assign clr_alock[m] = wr_status & reg_wdata[BASE + ALOCK_BIT];
  end

  always_comb begin
    addr_ext         = '0;
    addr_ext[AW-1:0] = addr_q;
  end

  assign reg_rdata = reg_sel ? addr_ext : status_word;

endmodule

// File: rtl/bus_err_capture.sv
// Bus error status capture: top level.
module bus_err_capture
  import bes_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int AW        = 32,
  parameter int DW        = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MASTERS-1:0]    err_valid,
  input  logic [N_MASTERS-1:0]    err_slave,
  input  logic [N_MASTERS-1:0]    err_write,
  input  logic [N_MASTERS*AW-1:0] err_addr,
  input  logic                    reg_wr,
  input  logic                    reg_sel,
  input  logic [DW-1:0]           reg_wdata,
  output logic [DW-1:0]           reg_rdata
);

  localparam int USED_W = N_MASTERS * FIELD_W;

  mst_field_t [N_MASTERS-1:0] fld;
  logic [N_MASTERS-1:0]       clr_flock;
  logic [N_MASTERS-1:0]       clr_alock;
  logic [N_MASTERS-1:0]       set_alock;
  logic [N_MASTERS-1:0]       alock_vec;
  logic [AW-1:0]              addr_q;
  logic [DW-1:0]              status_word;

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_mst
    bes_field u_field (
      .clk       (clk),
      .rst_n     (rst_n),
      .err_valid (err_valid[m]),
      .err_slave (err_slave[m]),
      .err_write (err_write[m]),
      .clr_flock (clr_flock[m]),
      .clr_alock (clr_alock[m]),
      .set_alock (set_alock[m]),
      .fld       (fld[m])
    );
    assign alock_vec[m] = fld[m].alock;
  end

  // Reserved upper bits read zero (R8).
  always_comb begin
    status_word             = '0;
    status_word[USED_W-1:0] = fld;
  end

  bes_addr_cap #(
    .N_MASTERS (N_MASTERS),
    .AW        (AW)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_valid (err_valid),
    .err_addr  (err_addr),
    .alock_any (|alock_vec),
    .set_alock (set_alock),
    .addr_q    (addr_q)
  );

  bes_regif #(
    .N_MASTERS (N_MASTERS),
    .AW        (AW),
    .DW        (DW)
  ) u_regif (
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .status_word (status_word),
    .addr_q      (addr_q),
    .clr_flock   (clr_flock),
    .clr_alock   (clr_alock),
    .reg_rdata   (reg_rdata)
  );

endmodule

// File: rtl/bes_checker.sv
// Property checker, bound onto bus_err_capture.
module bes_checker
  import bes_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int AW        = 32,
  parameter int DW        = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] err_valid,
  input logic [N_MASTERS-1:0] err_slave,
  input logic [N_MASTERS-1:0] err_write,
  input logic                 reg_wr,
  input logic                 reg_sel,
  input logic [DW-1:0]        reg_wdata,
  input logic [DW-1:0]        status_word,
  input logic [AW-1:0]        addr_word
);

  localparam int USED_W = N_MASTERS * FIELD_W;

  logic [N_MASTERS-1:0] alocks;

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_m
    localparam int B = m * FIELD_W;
    logic clr_f;
    assign alocks[m] = status_word[B + ALOCK_BIT];
    assign clr_f     = reg_wr && !reg_sel && reg_wdata[B + FLOCK_BIT];

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid[m] && !status_word[B + FLOCK_BIT]) |=>
        (status_word[B + FLOCK_BIT] &&
         status_word[B + 1 : B] == ($past(err_slave[m]) ? 2'b10 : 2'b01) &&
         status_word[B + RW_BIT] == $past(err_write[m])));

    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word[B + FLOCK_BIT] && !clr_f) |=>
        ($stable(status_word[B + RW_BIT : B]) && status_word[B + FLOCK_BIT]));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word[B + FLOCK_BIT] && clr_f) |=>
        (!status_word[B + FLOCK_BIT] && status_word[B + RW_BIT : B] == 3'b000));

    p_no_rsvd_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[B + 1 : B] != 2'b11);
  end

  p_alock_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alocks));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|alocks) |=> $stable(addr_word));

  if (USED_W < DW) begin : g_rsvd
    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[DW-1:USED_W] == '0);
  end

endmodule

bind bus_err_capture bes_checker #(
  .N_MASTERS (N_MASTERS),
  .AW        (AW),
  .DW        (DW)
) u_bes_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .err_valid   (err_valid),
  .err_slave   (err_slave),
  .err_write   (err_write),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .reg_wdata   (reg_wdata),
  .status_word (status_word),
  .addr_word   (addr_q)
);

// File: tb/test_bus_err_capture.sv
`timescale 1ns/1ps
module test_bus_err_capture;

  localparam int N  = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    err_valid;
  logic [N-1:0]    err_slave;
  logic [N-1:0]    err_write;
  logic [N*AW-1:0] err_addr;
  logic            reg_wr;
  logic            reg_sel;
  logic [DW-1:0]   reg_wdata;
  logic [DW-1:0]   reg_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state built from the requirements.
  logic [1:0]    m_code [N];
  logic          m_rw   [N];
  logic          m_fl   [N];
  logic          m_al   [N];
  logic [AW-1:0] m_addr;

  always #10 clk = ~clk;

  bus_err_capture #(.N_MASTERS(N), .AW(AW), .DW(DW)) i_bus_err_capture (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_slave(err_slave),
    .err_write(err_write), .err_addr(err_addr), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [DW-1:0] exp_status();
    logic [DW-1:0] w = '0;
    for (int m = 0; m < N; m++)
      w[m*5 +: 5] = {m_al[m], m_fl[m], m_rw[m], m_code[m]};
    return w;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    err_valid = '0; err_slave = '0; err_write = '0; err_addr = '0;
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  // Reads both registers at the falling edge and compares them with the model.
  task automatic verify(input string tag);
    reg_sel = 1'b0; #1;
    check({tag, " status"}, reg_rdata, exp_status());
    check("R8 reserved bits", reg_rdata[DW-1:N*5], '0);
    reg_sel = 1'b1; #1;
    check({tag, " address"}, reg_rdata, m_addr);
    reg_sel = 1'b0;
  endtask

  // Applies one cycle of stimulus and advances the model per R2..R10.
  task automatic cycle(input logic [N-1:0] ev, input logic [N-1:0] sl,
                       input logic [N-1:0] wr_acc, input logic [N*AW-1:0] ad,
                       input logic wr, input logic sel, input logic [DW-1:0] wd,
                       input string tag);
    bit any_al;
    bit won;
    err_valid = ev; err_slave = sl; err_write = wr_acc; err_addr = ad;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    any_al = 0;
    for (int m = 0; m < N; m++) any_al |= m_al[m];
    won = 0;
    for (int m = 0; m < N; m++) begin
      if (ev[m] && !m_fl[m]) begin
        m_code[m] = sl[m] ? 2'b10 : 2'b01;
        m_rw[m]   = wr_acc[m];
        m_fl[m]   = 1'b1;
      end else if (wr && !sel && wd[m*5+3]) begin
        m_code[m] = 2'b00; m_rw[m] = 1'b0; m_fl[m] = 1'b0;
      end
      if (!any_al && ev[m] && !won) begin
        won = 1;
        m_al[m] = 1'b1;
        m_addr  = ad[m*AW +: AW];
      end else if (wr && !sel && wd[m*5+4]) begin
        m_al[m] = 1'b0;
      end
    end
    @(negedge clk);
    idle();
    verify(tag);
  endtask

  function automatic logic [N*AW-1:0] addrs(input int m, input logic [AW-1:0] a);
    logic [N*AW-1:0] v = '0;
    v[m*AW +: AW] = a;
    return v;
  endfunction

  initial begin
    #4_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*AW-1:0] ad;
    void'($urandom(32'd2024));
    idle();
    rst_n = 1'b0;
    for (int m = 0; m < N; m++) begin
      m_code[m] = 0; m_rw[m] = 0; m_fl[m] = 0; m_al[m] = 0;
    end
    m_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    verify("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R4: master 2 timeout on a read
    cycle(4'b0100, 4'b0000, 4'b0000, addrs(2, 32'hA000_0010), 0, 0, '0, "R2 R4 capture");
    reg_sel = 1'b0; #1;
    check("R2 literal field", reg_rdata, 32'h0000_6400);
    // R3: master 2 locked, new slave write error ignored
    cycle(4'b0100, 4'b0100, 4'b0100, addrs(2, 32'hBBBB_0000), 0, 0, '0, "R3 locked");
    // R2/R4: master 0 slave write stored, address held by master 2
    cycle(4'b0001, 4'b0001, 4'b0001, addrs(0, 32'hC0C0_0004), 0, 0, '0, "R4 addr held");
    reg_sel = 1'b1; #1;
    check("R4 literal addr", reg_rdata, 32'hA000_0010);
    // R6/R9: ones only in code, R/W and reserved bits
    cycle('0, '0, '0, '0, 1, 0, 32'hFFF0_0000 | 32'h0001_8C63 & ~32'h0000_0000 & 32'h0007_39CE | 32'hFFF0_0000, "R6 R9 no clear");
    cycle('0, '0, '0, '0, 1, 1, 32'hFFFF_FFFF, "R9 addr write");
    // R7: release master 2 address lock, value stays
    cycle('0, '0, '0, '0, 1, 0, 32'h0000_4000, "R7 alock clear");
    reg_sel = 1'b1; #1;
    check("R7 literal addr", reg_rdata, 32'hA000_0010);
    // R5: masters 1 and 3 at once, master 1 wins
    ad = addrs(1, 32'h1111_1111) | addrs(3, 32'h3333_3333);
    cycle(4'b1010, 4'b1000, 4'b0010, ad, 0, 0, '0, "R5 tie");
    reg_sel = 1'b1; #1;
    check("R5 literal addr", reg_rdata, 32'h1111_1111);
    // R10: clear master 1 field lock while it reports again
    cycle(4'b0010, 4'b0010, 4'b0000, addrs(1, 32'h2222_0000), 1, 0, 32'h0000_0100, "R10 race");
    // R10: clear master 1 address lock while master 0 reports
    cycle(4'b0001, 4'b0000, 4'b0000, addrs(0, 32'h4444_0000), 1, 0, 32'h0000_0200, "R10 addr race");
    // R6/R7: clear everything
    cycle('0, '0, '0, '0, 1, 0, 32'hFFFF_FFFF, "R6 R7 clear all");
    reg_sel = 1'b0; #1;
    check("R6 literal cleared", reg_rdata, 32'h0000_0000);

    // Random mix covering R2, R3, R4, R5, R6, R7, R10
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] ev, sl, wa;
      logic [DW-1:0] wd;
      logic wr, sel;
      ev = '0;
      for (int m = 0; m < N; m++) ev[m] = ($urandom % 4) == 0;
      sl = N'($urandom); wa = N'($urandom);
      for (int m = 0; m < N; m++) ad[m*AW +: AW] = $urandom;
      wr = ($urandom % 3) == 0;
      sel = ($urandom % 5) == 0;
      wd = $urandom;
      cycle(ev, sl, wa, ad, wr, sel, wd, "R2/R3/R4/R5/R6/R7/R10 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule